// File: doc/BRIEF.md
# SPI Read Capture Delay Calibrator

This block is a hardware sequencer that picks the read-data capture delay a SPI flash controller should use at a given serial clock. It first asks the flash-read engine to fetch the 24-bit identification word. That fetch runs on the slow, safe reference clock with a capture delay of zero. This word is the reference. The block then moves the engine to the requested clock, clamped to a configured ceiling. It tries each capture delay code from zero upward and reads the identification word again at each code. The first contiguous run of codes that returns the reference word forms the passing window. The block programs the truncated midpoint of that window.

The block drives a command port toward the flash-read engine. That port carries a slow-clock select, the target clock in kHz, the delay code, a controller enable and an ID-read request. The engine answers each request with a one-cycle acknowledge, a 24-bit result and an error flag. The controller is always disabled while the delay code changes. A repeated request for the same clamped clock and the same chip select is answered at once, without any flash traffic, provided the previous calibration succeeded. The result is given as a one-cycle done pulse, a fail flag, the window bounds and the chosen code.

Top module: `rdcap_calibrator`

## Requirements
- R1: After a start that needs calibration, the first ID read is issued with eng_slow_clk high, eng_delay at 0 and eng_en high. Its 24-bit result becomes the reference word.
- R2: An ID read is a request held high until the engine acknowledges it. The 24-bit result is taken only in the acknowledge cycle, and every later result is compared with the reference word for equality.
- R3: After the reference read, eng_slow_clk goes low and the sweep issues one read for each delay code, in the order 0, 1, 2 and upward, without skipping a code.
- R4: A new delay code is presented only while eng_en is low. eng_en is raised again before each sweep read.
- R5: win_lo is the first code whose result equals the reference. The first mismatch after win_lo ends the sweep, and win_hi is then the code just before it. Later passing codes are ignored.
- R6: If no mismatch follows win_lo, win_hi is the last code, 2^DLY_W-1. The sweep issues 2^DLY_W reads in all.
- R7: If no code ever matches, done comes with fail high and win_valid low. chosen keeps its previous value and eng_en is left low.
- R8: On success, eng_delay is set to floor((win_lo+win_hi)/2) with eng_en low. Then eng_en rises, chosen takes that code, win_valid goes high and done pulses.
- R9: A start whose clamped clock and chip select both equal those of the last successful calibration issues no read. done comes in the cycle after the start edge, with fail low and the results unchanged. A change in either value, or an earlier failure, forces a full run.
- R10: The clock presented on eng_clk_khz is min(req_clk_khz, max_clk_khz). Skip decisions use this clamped value.
- R11: An acknowledge with eng_id_err high, on the reference read or on any sweep read, ends the run at once. done then comes with fail high, win_valid low, eng_en low and no further reads.
- R12: done is a one-cycle pulse. fail is valid with done and holds until the next start. After reset, done, busy, eng_en and win_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request calibration; taken only while idle |
| req_clk_khz | input | CLKW | Requested serial clock, kHz |
| req_cs | input | CSW | Chip select the calibration is for |
| max_clk_khz | input | CLKW | Clock ceiling, kHz |
| eng_slow_clk | output | 1 | Engine uses the slow reference clock |
| eng_clk_khz | output | CLKW | Clamped target clock for the engine |
| eng_delay | output | DLY_W | Capture delay code |
| eng_en | output | 1 | Controller enable |
| eng_id_req | output | 1 | ID-read request |
| eng_id_ack | input | 1 | ID-read acknowledge, one cycle |
| eng_id_err | input | 1 | Error flag, valid with acknowledge |
| eng_id_data | input | IDW | ID read result, valid with acknowledge |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Last run failed |
| win_valid | output | 1 | Window bounds and chosen code are valid |
| win_lo | output | DLY_W | Lower bound of passing window |
| win_hi | output | DLY_W | Upper bound of passing window |
| chosen | output | DLY_W | Programmed capture delay code |

## Verification
A skipped run shows done one cycle after the start edge. The bench checks that exact cycle against its own cycle count. A full run lasts a number of cycles set by the engine latency. The checks therefore wait for the done pulse and sample every output at the falling edge of that cycle. The number of reads must equal the count the bench model predicts: one reference read plus one read for each code up to the end of the window, the mismatch or the error. The stand-in engine checks each request as it acknowledges it. It confirms the slow select and code 0 for the reference read, and the enable and the next code in order for each sweep read.

// File: rtl/rdcap_pkg.sv
package rdcap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REF_ON,
    ST_REF_RD,
    ST_SW_ON,
    ST_SW_RD,
    ST_PROG,
    ST_DONE
  } cal_state_e;
endpackage

// File: rtl/rdcap_window.sv
// Tracks the first contiguous passing window during the sweep.
module rdcap_window #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [DLY_W-1:0] idx,
  input  logic             match,
  output logic [DLY_W-1:0] lo,
  output logic [DLY_W-1:0] hi,
  output logic             nxt_found,
  output logic [DLY_W-1:0] nxt_lo,
  output logic [DLY_W-1:0] nxt_hi,
  output logic             stop
);
  logic found_q;

  always_comb begin
    nxt_found = found_q | match;
    nxt_lo    = (!found_q && match) ? idx : lo;
    nxt_hi    = match ? idx : hi;
    stop      = found_q && !match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found_q <= 1'b0;
      lo      <= '0;
      hi      <= '0;
    end else if (clear) begin
      found_q <= 1'b0;
      lo      <= '0;
      hi      <= '0;
    end else if (step) begin
      found_q <= nxt_found;
      lo      <= nxt_lo;
      hi      <= nxt_hi;
    end
  end
endmodule

// File: rtl/rdcap_memo.sv
// Remembers the clock and chip select of the last successful calibration.
module rdcap_memo #(
  parameter int CLKW = 20,
  parameter int CSW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            drop,
  input  logic            record,
  input  logic [CLKW-1:0] rec_clk,
  input  logic [CSW-1:0]  rec_cs,
  input  logic [CLKW-1:0] ask_clk,
  input  logic [CSW-1:0]  ask_cs,
  output logic            hit
);
  logic            ok_q;
  logic [CLKW-1:0] clk_q;
  logic [CSW-1:0]  cs_q;

  assign hit = ok_q && (clk_q == ask_clk) && (cs_q == ask_cs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q  <= 1'b0;
      clk_q <= '0;
      cs_q  <= '0;
    end else if (record) begin
      ok_q  <= 1'b1;
      clk_q <= rec_clk;
      cs_q  <= rec_cs;
    end else if (drop) begin
      ok_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rdcap_calibrator.sv
module rdcap_calibrator #(
  parameter int DLY_W = 4,
  parameter int CLKW  = 20,
  parameter int CSW   = 2,
  parameter int IDW   = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CLKW-1:0]  req_clk_khz,
  input  logic [CSW-1:0]   req_cs,
  input  logic [CLKW-1:0]  max_clk_khz,
  output logic             eng_slow_clk,
  output logic [CLKW-1:0]  eng_clk_khz,
  output logic [DLY_W-1:0] eng_delay,
  output logic             eng_en,
  output logic             eng_id_req,
  input  logic             eng_id_ack,
  input  logic             eng_id_err,
  input  logic [IDW-1:0]   eng_id_data,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic             win_valid,
  output logic [DLY_W-1:0] win_lo,
  output logic [DLY_W-1:0] win_hi,
  output logic [DLY_W-1:0] chosen
);
  import rdcap_pkg::*;

  localparam int NDELAY = 1 << DLY_W;
  localparam logic [DLY_W-1:0] LAST_DLY = DLY_W'(NDELAY - 1);

  function automatic logic [CLKW-1:0] clamp_khz(input logic [CLKW-1:0] want,
                                                input logic [CLKW-1:0] limit);
    return (want > limit) ? limit : want;
  endfunction

  function automatic logic [DLY_W-1:0] window_mid(input logic [DLY_W-1:0] a,
                                                  input logic [DLY_W-1:0] b);
    logic [DLY_W:0] sum;
    sum = {1'b0, a} + {1'b0, b};
    return sum[DLY_W:1];
  endfunction

  cal_state_e       state;
  logic [CLKW-1:0]  tgt_clk;
  logic [CSW-1:0]   cs_q;
  logic [DLY_W-1:0] idx;
  logic [IDW-1:0]   ref_id;
  logic             en_q, slow_q, req_q, fail_q, valid_q;
  logic [DLY_W-1:0] dly_q, chosen_q;

  // Named internal events
  wire [CLKW-1:0] want_clk   = clamp_khz(req_clk_khz, max_clk_khz);
  wire            id_ok      = eng_id_ack && !eng_id_err;
  wire            id_bad     = eng_id_ack && eng_id_err;
  wire            ref_phase  = (state == ST_REF_RD);
  wire            sweep_step = (state == ST_SW_RD) && id_ok;
  wire            abort      = (ref_phase || state == ST_SW_RD) && id_bad;
  wire            id_match   = (eng_id_data == ref_id);
  wire            launch     = (state == ST_IDLE) && start;

  logic             memo_hit;
  logic             w_nxt_found, w_stop;
  logic [DLY_W-1:0] w_nxt_lo, w_nxt_hi;

  wire rerun     = launch && !memo_hit;
  wire sweep_end = sweep_step && (w_stop || idx == LAST_DLY);

  rdcap_memo #(.CLKW(CLKW), .CSW(CSW)) u_memo (
    .clk     (clk),
    .rst_n   (rst_n),
    .drop    (rerun),
    .record  (state == ST_PROG),
    .rec_clk (tgt_clk),
    .rec_cs  (cs_q),
    .ask_clk (want_clk),
    .ask_cs  (req_cs),
    .hit     (memo_hit)
  );

  rdcap_window #(.DLY_W(DLY_W)) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (rerun),
    .step      (sweep_step),
    .idx       (idx),
    .match     (id_match),
    .lo        (win_lo),
    .hi        (win_hi),
    .nxt_found (w_nxt_found),
    .nxt_lo    (w_nxt_lo),
    .nxt_hi    (w_nxt_hi),
    .stop      (w_stop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      tgt_clk  <= '0;
      cs_q     <= '0;
      idx      <= '0;
      ref_id   <= '0;
      en_q     <= 1'b0;
      slow_q   <= 1'b0;
      req_q    <= 1'b0;
      fail_q   <= 1'b0;
      valid_q  <= 1'b0;
      dly_q    <= '0;
      chosen_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          tgt_clk <= want_clk;
          cs_q    <= req_cs;
          fail_q  <= 1'b0;
          if (memo_hit) begin
            en_q  <= 1'b1;
            state <= ST_DONE;
          end else begin
            en_q    <= 1'b0;
            slow_q  <= 1'b1;
            dly_q   <= '0;
            valid_q <= 1'b0;
            state   <= ST_REF_ON;
          end
        end
        ST_REF_ON: begin
          en_q  <= 1'b1;
          req_q <= 1'b1;
          state <= ST_REF_RD;
        end
        ST_REF_RD: if (eng_id_ack) begin
          req_q  <= 1'b0;
          en_q   <= 1'b0;
          slow_q <= 1'b0;
          if (eng_id_err) begin
            fail_q <= 1'b1;
            state  <= ST_DONE;
          end else begin
            ref_id <= eng_id_data;
            idx    <= '0;
            dly_q  <= '0;
            state  <= ST_SW_ON;
          end
        end
        ST_SW_ON: begin
          en_q  <= 1'b1;
          req_q <= 1'b1;
          state <= ST_SW_RD;
        end
        ST_SW_RD: if (eng_id_ack) begin
          req_q <= 1'b0;
          en_q  <= 1'b0;
          if (eng_id_err) begin
            fail_q <= 1'b1;
            state  <= ST_DONE;
          end else if (sweep_end) begin
            if (!w_nxt_found) begin
              fail_q <= 1'b1;
              state  <= ST_DONE;
            end else begin
              dly_q <= window_mid(w_nxt_lo, w_nxt_hi);
              state <= ST_PROG;
            end
          end else begin
            idx   <= idx + 1'b1;
            dly_q <= idx + 1'b1;
            state <= ST_SW_ON;
          end
        end
        ST_PROG: begin
          en_q     <= 1'b1;
          valid_q  <= 1'b1;
          chosen_q <= dly_q;
          state    <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign eng_slow_clk = slow_q;
  assign eng_clk_khz  = tgt_clk;
  assign eng_delay    = dly_q;
  assign eng_en       = en_q;
  assign eng_id_req   = req_q;
  assign busy         = (state != ST_IDLE);
  assign done         = (state == ST_DONE);
  assign fail         = fail_q;
  assign win_valid    = valid_q;
  assign chosen       = chosen_q;
endmodule

// File: rtl/rdcap_calibrator_chk.sv
module rdcap_calibrator_chk #(
  parameter int DLY_W = 4,
  parameter int CLKW  = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eng_slow_clk,
  input logic [CLKW-1:0]  eng_clk_khz,
  input logic [CLKW-1:0]  max_clk_khz,
  input logic [DLY_W-1:0] eng_delay,
  input logic             eng_en,
  input logic             eng_id_req,
  input logic             eng_id_ack,
  input logic             done,
  input logic             fail,
  input logic             win_valid,
  input logic [DLY_W-1:0] win_lo,
  input logic [DLY_W-1:0] win_hi,
  input logic [DLY_W-1:0] chosen,
  input logic             sweep_step,
  input logic             abort
);
  assert_ref_at_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    eng_slow_clk |-> eng_delay == '0);

  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_id_req && !eng_id_ack |=> eng_id_req);

  assert_step_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_step |-> eng_en && !eng_slow_clk);

  assert_delay_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(eng_delay) |-> !eng_en);

  assert_req_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_id_req |-> eng_en);

  assert_window_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> win_lo <= win_hi);

  assert_mid_inside_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fail |-> win_valid && chosen >= win_lo && chosen <= win_hi && eng_en);

  assert_clamp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_id_req && !eng_slow_clk |-> eng_clk_khz <= max_clk_khz);

  assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> done && fail && !win_valid && !eng_en);

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind rdcap_calibrator rdcap_calibrator_chk #(.DLY_W(DLY_W), .CLKW(CLKW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .eng_slow_clk (eng_slow_clk),
  .eng_clk_khz  (eng_clk_khz),
  .max_clk_khz  (max_clk_khz),
  .eng_delay    (eng_delay),
  .eng_en       (eng_en),
  .eng_id_req   (eng_id_req),
  .eng_id_ack   (eng_id_ack),
  .done         (done),
  .fail         (fail),
  .win_valid    (win_valid),
  .win_lo       (win_lo),
  .win_hi       (win_hi),
  .chosen       (chosen),
  .sweep_step   (sweep_step),
  .abort        (abort)
);

// File: tb/rdcap_calibrator_test.sv
module rdcap_calibrator_test;
  localparam int CLK_PERIOD = 10;
  localparam int DLY_W = 4;
  localparam int N     = 1 << DLY_W;
  localparam int CLKW  = 20;
  localparam int CSW   = 2;
  localparam int IDW   = 24;
  localparam int LAT   = 3;

  logic             clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [CLKW-1:0]  req_clk_khz = '0, max_clk_khz = '0;
  logic [CSW-1:0]   req_cs = '0;
  logic             eng_slow_clk, eng_en, eng_id_req;
  logic [CLKW-1:0]  eng_clk_khz;
  logic [DLY_W-1:0] eng_delay;
  logic             eng_id_ack = 1'b0, eng_id_err = 1'b0;
  logic [IDW-1:0]   eng_id_data = '0;
  logic             busy, done, fail, win_valid;
  logic [DLY_W-1:0] win_lo, win_hi, chosen;

  rdcap_calibrator #(.DLY_W(DLY_W), .CLKW(CLKW), .CSW(CSW), .IDW(IDW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_clk_khz(req_clk_khz),
    .req_cs(req_cs), .max_clk_khz(max_clk_khz), .eng_slow_clk(eng_slow_clk),
    .eng_clk_khz(eng_clk_khz), .eng_delay(eng_delay), .eng_en(eng_en),
    .eng_id_req(eng_id_req), .eng_id_ack(eng_id_ack), .eng_id_err(eng_id_err),
    .eng_id_data(eng_id_data), .busy(busy), .done(done), .fail(fail),
    .win_valid(win_valid), .win_lo(win_lo), .win_hi(win_hi), .chosen(chosen)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, st_cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // Stand-in flash-read engine
  logic [N-1:0]   pass_mask = '0;
  logic [IDW-1:0] ref_val = '0;
  bit  err_ref = 0;
  int  err_dly = -1, reads = 0, nxt_dly = 0, rsp_cnt = 0, exp_clk = 0;
  bit  seq_ok = 1, ref_ok = 1;

  always @(negedge clk) begin
    if (!rst_n) begin
      eng_id_ack = 1'b0; rsp_cnt = 0;
    end else if (eng_id_ack) begin
      eng_id_ack = 1'b0; eng_id_err = 1'b0;
    end else if (eng_id_req) begin
      if (rsp_cnt == LAT - 1) begin
        rsp_cnt = 0;
        reads++;
        eng_id_ack = 1'b1;
        if (eng_slow_clk) begin
          if (!(eng_delay == 0 && eng_en && reads == 1)) ref_ok = 0;
          eng_id_data = ref_val;
          eng_id_err  = err_ref;
        end else begin
          if (!(eng_en && int'(eng_delay) == nxt_dly && int'(eng_clk_khz) == exp_clk))
            seq_ok = 0;
          nxt_dly++;
          eng_id_data = pass_mask[eng_delay] ? ref_val : (ref_val ^ 24'h00A5C3);
          eng_id_err  = (int'(eng_delay) == err_dly);
        end
      end else rsp_cnt++;
    end
  end

  typedef struct {
    string tag; bit fail; bit wv; int lo; int hi; int chosen;
    int reads; int clk; bit en; int lat;
  } exp_t;
  exp_t q[$];

  // Bench-side model state
  bit memo_ok = 0; int memo_clk = 0, memo_cs = 0;
  int last_lo = 0, last_hi = 0, last_ch = 0; bit last_wv = 0;

  task automatic run(string tag, int rclk, int cs, int mx, logic [N-1:0] m,
                     logic [IDW-1:0] rv, bit eref, int edly);
    exp_t e;
    int want = (rclk > mx) ? mx : rclk;
    bit skip = memo_ok && memo_clk == want && memo_cs == cs;
    e.tag = tag; e.clk = want;
    if (skip) begin
      e.fail = 0; e.wv = last_wv; e.lo = last_lo; e.hi = last_hi;
      e.chosen = last_ch; e.reads = 0; e.en = 1; e.lat = 1;
    end else begin
      int lo = -1, hi = -1, rd = N + 1; bit f = 0;
      memo_ok = 0;
      if (eref) begin f = 1; rd = 1; end
      else begin
        for (int d = 0; d < N; d++) begin
          if (d == edly) begin f = 1; rd = d + 2; break; end
          if (m[d]) begin
            if (lo < 0) lo = d;
            hi = d;
          end else if (lo >= 0) begin
            rd = d + 2; break;
          end
        end
        if (lo < 0) f = 1;
      end
      e.reads = rd; e.lat = -1; e.fail = f; e.lo = lo; e.hi = hi;
      if (f) begin
        e.wv = 0; e.chosen = last_ch; e.en = 0; last_wv = 0;
      end else begin
        e.wv = 1; e.chosen = (lo + hi) / 2; e.en = 1;
        last_lo = lo; last_hi = hi; last_ch = e.chosen; last_wv = 1;
        memo_ok = 1; memo_clk = want; memo_cs = cs;
      end
    end
    pass_mask = m; ref_val = rv; err_ref = eref; err_dly = edly;
    reads = 0; nxt_dly = 0; seq_ok = 1; ref_ok = 1; exp_clk = want;
    q.push_back(e);
    @(negedge clk);
    req_clk_khz = CLKW'(rclk); req_cs = CSW'(cs); max_clk_khz = CLKW'(mx);
    start = 1'b1; st_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Scoreboard monitor
  exp_t got;
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) chk("R12 unexpected done", 1, 0);
      else begin
        got = q.pop_front();
        chk({got.tag, " R12 fail flag"}, int'(fail), int'(got.fail));
        chk({got.tag, " R11 win_valid"}, int'(win_valid), int'(got.wv));
        chk({got.tag, " R7 R8 chosen"}, int'(chosen), got.chosen);
        chk({got.tag, " R8 eng_en at done"}, int'(eng_en), int'(got.en));
        chk({got.tag, " R9 R11 read count"}, reads, got.reads);
        chk({got.tag, " R10 clamped clock"}, int'(eng_clk_khz), got.clk);
        if (!got.fail) begin
          chk({got.tag, " R5 win_lo"}, int'(win_lo), got.lo);
          chk({got.tag, " R6 win_hi"}, int'(win_hi), got.hi);
        end
        if (got.reads > 0) chk({got.tag, " R1 reference read"}, int'(ref_ok), 1);
        if (got.reads > 1) chk({got.tag, " R3 R4 sweep order"}, int'(seq_ok), 1);
        if (got.lat >= 0) chk({got.tag, " R9 skip latency"}, cyc - st_cyc, got.lat);
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R12 watchdog: actual no done expected done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset done", int'(done), 0);
    chk("R12 reset busy", int'(busy), 0);
    chk("R12 reset eng_en", int'(eng_en), 0);
    chk("R12 reset win_valid", int'(win_valid), 0);

    run("R5 single window",        50000, 0, 100000, 16'h00F0, 24'hC22018, 0, -1);
    run("R9 repeat skip",          50000, 0, 100000, 16'h00F0, 24'hC22018, 0, -1);
    run("R6 tail window new cs",   50000, 1, 100000, 16'hF000, 24'hC22018, 0, -1);
    run("R2 R5 first of two",      40000, 1, 100000, 16'h0E38, 24'h1F4401, 0, -1);
    run("R7 no match",             30000, 1, 100000, 16'h0000, 24'h1F4401, 0, -1);
    run("R9 rerun after fail",     30000, 1, 100000, 16'h0006, 24'h1F4401, 0, -1);
    run("R10 clamp",              200000, 1, 100000, 16'h0001, 24'h9D6017, 0, -1);
    run("R10 clamp skip",         150000, 1, 100000, 16'h0001, 24'h9D6017, 0, -1);
    run("R11 sweep error",         60000, 0, 100000, 16'h00F0, 24'hC22018, 0, 6);
    run("R11 reference error",     60000, 0, 100000, 16'h00F0, 24'hC22018, 1, -1);
    run("R8 R6 full pass",         70000, 2, 100000, 16'hFFFF, 24'hEF4018, 0, -1);
    run("R9 clock change",         80000, 2, 100000, 16'h0180, 24'hEF4018, 0, -1);
    finish_run();
  end
endmodule